// File: doc/BRIEF.md
# Transmit Capture Clock Source Selector

This block sits in front of a four-lane 10-bit parallel transmit port. It chooses where the capture timing for each lane's character comes from. All its inputs are sampled by one fast synchronous clock: the reference clock, a shared byte clock, an auxiliary byte-clock activity input, a single/double-rate select and one byte clock per lane. The block counts rising edges on the shared and auxiliary byte clocks over fixed windows and marks each one as toggling or static. From that verdict it picks one of four capture schemes and raises a one-cycle valid strobe with each captured character.

In the two byte-clock schemes a lock input controls the timing. While it is low, captures follow the byte clock, and the block notes where each byte-clock edge falls within the reference period. After it goes high, captures happen at that noted reference phase. Later drift of the byte clock then has no effect. The current scheme is available as a 2-bit code. A tracking flag shows when the byte clock is being followed.

Top module: `tx_clksrc_detect`

## Requirements
- R1: At the end of every 64-cycle window, each of the shared and auxiliary byte clocks is marked toggling if it showed at least 2 rising edges in that window, and static otherwise. The edge counts then restart.
- R2: The window verdict names a scheme, which mode_o reports as a code:
  - shared static and ref_single_i high gives 00 (reference).
  - shared static and ref_single_i low gives 01 (double rate).
  - shared toggling and auxiliary static gives 10 (shared byte clock).
  - both toggling gives 11 (per lane).
- R3: mode_o changes only at a window end, and only after 2 consecutive window verdicts have named the same new scheme. A single differing verdict leaves mode_o unchanged.
- R4: In scheme 00, all lanes capture on each reference rising edge. The character and a one-cycle valid appear one sampling cycle later.
- R5: In scheme 01, all lanes also capture at the midpoint. The midpoint is the cycle where the number of cycles since the last reference rise equals half (rounded down) of the measured period. The period is the spacing of the last two reference rises, so no midpoint capture occurs before two reference rises have been seen.
- R6: In scheme 10 with lock_ref_i low, all lanes capture on rising edges of the shared byte clock.
- R7: In scheme 11 with lock_ref_i low, each lane captures on rising edges of its own byte clock.
- R8: In schemes 10 and 11 with lock_ref_i high, each lane captures once per reference period. It does so at the reference phase its byte clock edge last had while lock_ref_i was low, and byte-clock edges that move after that are ignored.
- R9: bclk_track_o is high one cycle after a cycle in which the scheme was 10 or 11 and lock_ref_i was low, and low otherwise.
- R10: Lane i occupies char_o and lane_data_i bits [10i+9:10i]. Bit 10i is the first serial bit of that lane's character.
- R11: During reset, mode_o is 00 and valid_o, char_o and bclk_track_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_clk_i | input | 1 | Reference clock level |
| shared_bclk_i | input | 1 | Shared transmit byte clock level |
| bclk_aux_i | input | 1 | Auxiliary byte-clock activity input |
| ref_single_i | input | 1 | High: one capture per reference period; low: two |
| lane_bclk_i | input | 4 | Per-lane byte clock levels |
| lock_ref_i | input | 1 | Low: follow the byte clock; high: hold reference phase |
| lane_data_i | input | 40 | Four 10-bit lane characters |
| char_o | output | 40 | Captured characters, same lane layout |
| valid_o | output | 4 | One-cycle capture strobe per lane |
| mode_o | output | 2 | Selected capture scheme code |
| bclk_track_o | output | 1 | Byte clock currently being followed |

## Verification
Each scheme is entered in turn: static shared clock under both rate selections, toggling shared clock, then toggling auxiliary and lane clocks. Lane data changes on every cycle, so a capture one cycle early or late shows up as a wrong character. The lane clocks have distinct phases, which separates per-lane timing from shared timing. A one-window rate change tests the debounce, and a shared clock with one pulse per 100 cycles tests the edge threshold. In the shared-clock scheme, the byte clock is shifted by one cycle after lock. This shows whether capture stays on the reference phase or follows the drifted edge.

// File: rtl/txsrc_pkg.sv
package txsrc_pkg;
    typedef enum logic [1:0] {
        SRC_REF  = 2'b00,
        SRC_DBL  = 2'b01,
        SRC_SHR  = 2'b10,
        SRC_LANE = 2'b11
    } src_mode_e;
endpackage

// File: rtl/txsrc_edge.sv
module txsrc_edge #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] sig_i,
    output logic [N-1:0] rise_o
);
    typedef struct packed {
        logic [N-1:0] prev;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = sig_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise_o = sig_i & ~st_q.prev;
endmodule

// File: rtl/txsrc_phase.sv
module txsrc_phase #(
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ref_rise_i,
    output logic [PW-1:0] ph_o,
    output logic          mid_o
);
    localparam logic [PW-1:0] PH_MAX = '1;

    typedef struct packed {
        logic [PW-1:0] ph;
        logic [PW-1:0] period;
        logic          seen;
    } ph_st_t;

    ph_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ref_rise_i) begin
            st_d.ph = PW'(1);
            if (st_q.seen) st_d.period = st_q.ph;
            st_d.seen = 1'b1;
        end else if (st_q.ph != PH_MAX) begin
            st_d.ph = st_q.ph + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ph_o  = st_q.ph;
    assign mid_o = (st_q.period != '0) && (st_q.ph == (st_q.period >> 1)) && !ref_rise_i;
endmodule

// File: rtl/txsrc_activity.sv
module txsrc_activity
    import txsrc_pkg::*;
#(
    parameter int WIN       = 64,
    parameter int MIN_EDGES = 2,
    parameter int HOLD      = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      shr_rise_i,
    input  logic      aux_rise_i,
    input  logic      ref_single_i,
    output src_mode_e mode_o,
    output logic      win_end_o
);
    localparam int WW = (WIN > 1) ? $clog2(WIN) : 1;
    localparam int EW = $clog2(MIN_EDGES + 1);
    localparam int HW = $clog2(HOLD + 1);

    typedef struct packed {
        logic [WW-1:0] win;
        logic [EW-1:0] shr_cnt;
        logic [EW-1:0] aux_cnt;
        logic [HW-1:0] streak;
        src_mode_e     pend;
        src_mode_e     mode;
    } act_st_t;

    act_st_t       st_d, st_q;
    logic          win_end;
    logic [EW-1:0] shr_tot, aux_tot;
    logic          shr_tog, aux_tog;
    src_mode_e     cand;
    logic [HW-1:0] nxt;

    always_comb begin
        st_d    = st_q;
        win_end = (st_q.win == WW'(WIN - 1));
        shr_tot = (shr_rise_i && st_q.shr_cnt < EW'(MIN_EDGES)) ? st_q.shr_cnt + 1'b1 : st_q.shr_cnt;
        aux_tot = (aux_rise_i && st_q.aux_cnt < EW'(MIN_EDGES)) ? st_q.aux_cnt + 1'b1 : st_q.aux_cnt;
        shr_tog = (shr_tot >= EW'(MIN_EDGES));
        aux_tog = (aux_tot >= EW'(MIN_EDGES));
        if (shr_tog) cand = aux_tog ? SRC_LANE : SRC_SHR;
        else         cand = ref_single_i ? SRC_REF : SRC_DBL;
        nxt = (cand == st_q.pend) ? st_q.streak + 1'b1 : HW'(1);

        if (win_end) begin
            st_d.win     = '0;
            st_d.shr_cnt = '0;
            st_d.aux_cnt = '0;
            if (cand == st_q.mode) begin
                st_d.streak = '0;
            end else if (nxt >= HW'(HOLD)) begin
                st_d.mode   = cand;
                st_d.streak = '0;
                st_d.pend   = cand;
            end else begin
                st_d.streak = nxt;
                st_d.pend   = cand;
            end
        end else begin
            st_d.win     = st_q.win + 1'b1;
            st_d.shr_cnt = shr_tot;
            st_d.aux_cnt = aux_tot;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.pend <= SRC_REF;
            st_q.mode <= SRC_REF;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_o    = st_q.mode;
    assign win_end_o = win_end;
endmodule

// File: rtl/txsrc_lane.sv
module txsrc_lane
    import txsrc_pkg::*;
#(
    parameter int CW = 10,
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  src_mode_e     mode_i,
    input  logic          lock_ref_i,
    input  logic          ref_rise_i,
    input  logic          mid_i,
    input  logic          bclk_rise_i,
    input  logic [PW-1:0] ph_i,
    input  logic [CW-1:0] data_i,
    output logic [CW-1:0] char_o,
    output logic          valid_o
);
    typedef struct packed {
        logic [CW-1:0] chr;
        logic          valid;
        logic [PW-1:0] offset;
    } lane_st_t;

    lane_st_t st_d, st_q;
    logic     strobe;

    always_comb begin
        st_d = st_q;
        if (mode_i[1]) begin
            if (!lock_ref_i) begin
                strobe = bclk_rise_i;
                if (bclk_rise_i) st_d.offset = ph_i;
            end else begin
                strobe = (ph_i == st_q.offset);
            end
        end else begin
            strobe = ref_rise_i || ((mode_i == SRC_DBL) && mid_i);
        end
        st_d.valid = strobe;
        if (strobe) st_d.chr = data_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign char_o  = st_q.chr;
    assign valid_o = st_q.valid;
endmodule

// File: rtl/tx_clksrc_detect.sv
module tx_clksrc_detect
    import txsrc_pkg::*;
#(
    parameter int NCH       = 4,
    parameter int CW        = 10,
    parameter int WIN       = 64,
    parameter int MIN_EDGES = 2,
    parameter int HOLD      = 2,
    parameter int PW        = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_clk_i,
    input  logic              shared_bclk_i,
    input  logic              bclk_aux_i,
    input  logic              ref_single_i,
    input  logic [NCH-1:0]    lane_bclk_i,
    input  logic              lock_ref_i,
    input  logic [NCH*CW-1:0] lane_data_i,
    output logic [NCH*CW-1:0] char_o,
    output logic [NCH-1:0]    valid_o,
    output logic [1:0]        mode_o,
    output logic              bclk_track_o
);
    localparam int NSIG = NCH + 3;

    typedef struct packed {
        logic track;
    } top_st_t;

    top_st_t         st_d, st_q;
    logic [NSIG-1:0] sig, rise;
    logic            ref_rise, shr_rise, aux_rise, mid, win_end;
    logic [NCH-1:0]  lane_rise;
    logic [PW-1:0]   ph;
    src_mode_e       mode;

    assign sig       = {lane_bclk_i, bclk_aux_i, shared_bclk_i, ref_clk_i};
    assign ref_rise  = rise[0];
    assign shr_rise  = rise[1];
    assign aux_rise  = rise[2];
    assign lane_rise = rise[NSIG-1:3];

    txsrc_edge #(.N(NSIG)) u_edge (
        .clk(clk), .rst_n(rst_n), .sig_i(sig), .rise_o(rise)
    );

    txsrc_phase #(.PW(PW)) u_phase (
        .clk(clk), .rst_n(rst_n), .ref_rise_i(ref_rise), .ph_o(ph), .mid_o(mid)
    );

    txsrc_activity #(.WIN(WIN), .MIN_EDGES(MIN_EDGES), .HOLD(HOLD)) u_act (
        .clk(clk), .rst_n(rst_n), .shr_rise_i(shr_rise), .aux_rise_i(aux_rise),
        .ref_single_i(ref_single_i), .mode_o(mode), .win_end_o(win_end)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_lane
        logic brise;
        assign brise = (mode == SRC_LANE) ? lane_rise[g] : shr_rise;
        txsrc_lane #(.CW(CW), .PW(PW)) u_lane (
            .clk(clk), .rst_n(rst_n), .mode_i(mode), .lock_ref_i(lock_ref_i),
            .ref_rise_i(ref_rise), .mid_i(mid), .bclk_rise_i(brise), .ph_i(ph),
            .data_i(lane_data_i[g*CW +: CW]), .char_o(char_o[g*CW +: CW]),
            .valid_o(valid_o[g])
        );
    end

    always_comb begin
        st_d       = st_q;
        st_d.track = mode[1] && !lock_ref_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mode_o       = mode;
    assign bclk_track_o = st_q.track;
endmodule

// File: rtl/tx_clksrc_detect_chk.sv
module tx_clksrc_detect_chk #(
    parameter int NCH = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic [1:0]     mode_o,
    input logic [NCH-1:0] valid_o,
    input logic           track_o,
    input logic           lock_ref_i,
    input logic           win_end,
    input logic           ref_rise,
    input logic           shr_rise,
    input logic           mid
);
    p_mode_at_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mode_o) |-> $past(win_end));

    p_ref_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode_o) == 2'b00 && valid_o[0]) |-> $past(ref_rise));

    p_dbl_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode_o) == 2'b01 && valid_o[0]) |-> ($past(ref_rise) || $past(mid)));

    p_shared_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode_o) == 2'b10 && !$past(lock_ref_i) && valid_o[0]) |-> $past(shr_rise));

    p_lanes_together_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode_o) != 2'b11) |-> (valid_o == '0 || valid_o == '1));

    p_track_r9: assert property (@(posedge clk) disable iff (!rst_n)
        track_o |-> ($past(mode_o[1]) && !$past(lock_ref_i)));
endmodule

bind tx_clksrc_detect tx_clksrc_detect_chk #(.NCH(NCH)) u_chk (
    .clk(clk), .rst_n(rst_n), .mode_o(mode_o), .valid_o(valid_o),
    .track_o(bclk_track_o), .lock_ref_i(lock_ref_i), .win_end(win_end),
    .ref_rise(ref_rise), .shr_rise(shr_rise), .mid(mid)
);

// File: tb/tx_clksrc_detect_tb.sv
module tx_clksrc_detect_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_s = 1'b0, shr_s = 1'b0, aux_s = 1'b0, single_s = 1'b1, lock_s = 1'b0;
    logic [3:0]  lane_s = '0;
    logic [39:0] data_s = '0;
    logic [39:0] char_o;
    logic [3:0]  valid_o;
    logic [1:0]  mode_o;
    logic        track_o;

    int n_chk = 0, n_fail = 0, cyc = 0;
    int shr_sel = 0, shr_ph = 3, aux_on = 0, lane_on = 0, hold_on = 0;
    logic [9:0] hold_v [4];

    // behavioural reference state
    int m_ph, m_per, m_seen, m_win, m_cs, m_ca, m_mode, m_pend, m_streak;
    int m_off [4];
    logic [9:0] e_char [4];
    logic e_valid [4];
    logic e_track;
    logic p_ref, p_shr, p_aux;
    logic [3:0] p_lane;
    string m_tag;

    always #5 clk = ~clk;

    tx_clksrc_detect u_dut (
        .clk(clk), .rst_n(rst_n), .ref_clk_i(ref_s), .shared_bclk_i(shr_s),
        .bclk_aux_i(aux_s), .ref_single_i(single_s), .lane_bclk_i(lane_s),
        .lock_ref_i(lock_s), .lane_data_i(data_s), .char_o(char_o),
        .valid_o(valid_o), .mode_o(mode_o), .bclk_track_o(track_o)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_per = 0; m_seen = 0; m_win = 0; m_cs = 0; m_ca = 0;
            m_mode = 0; m_pend = 0; m_streak = 0; e_track = 0;
            p_ref = 0; p_shr = 0; p_aux = 0; p_lane = '0; m_tag = "R4";
            for (int i = 0; i < 4; i++) begin m_off[i] = 0; e_char[i] = '0; e_valid[i] = 0; end
        end else begin
            bit rr, rs, ra, mid, st, b, ts, ta;
            int tot_s, tot_a, cand, nx;
            rr = ref_s && !p_ref; rs = shr_s && !p_shr; ra = aux_s && !p_aux;
            mid = (m_per != 0) && (m_ph == m_per / 2) && !rr;
            case (m_mode)
                0: m_tag = "R4";
                1: m_tag = "R5";
                2: m_tag = lock_s ? "R8" : "R6";
                default: m_tag = lock_s ? "R8" : "R7";
            endcase
            for (int i = 0; i < 4; i++) begin
                if (m_mode >= 2) begin
                    b = (m_mode == 3) ? (lane_s[i] && !p_lane[i]) : rs;
                    if (!lock_s) begin st = b; if (b) m_off[i] = m_ph; end
                    else st = (m_ph == m_off[i]);
                end else begin
                    st = rr || (m_mode == 1 && mid);
                end
                e_valid[i] = st;
                if (st) e_char[i] = data_s[i*10 +: 10];
            end
            e_track = (m_mode >= 2) && !lock_s;
            if (rr) begin if (m_seen != 0) m_per = m_ph; m_seen = 1; m_ph = 1; end
            else if (m_ph < 255) m_ph++;
            tot_s = m_cs + ((rs && m_cs < 2) ? 1 : 0);
            tot_a = m_ca + ((ra && m_ca < 2) ? 1 : 0);
            if (m_win == 63) begin
                ts = tot_s >= 2; ta = tot_a >= 2;
                cand = ts ? (ta ? 3 : 2) : (single_s ? 0 : 1);
                if (cand == m_mode) m_streak = 0;
                else begin
                    nx = (cand == m_pend) ? m_streak + 1 : 1;
                    m_pend = cand;
                    if (nx >= 2) begin m_mode = cand; m_streak = 0; end
                    else m_streak = nx;
                end
                m_win = 0; m_cs = 0; m_ca = 0;
            end else begin
                m_win++; m_cs = tot_s; m_ca = tot_a;
            end
            p_ref = ref_s; p_shr = shr_s; p_aux = aux_s; p_lane = lane_s;
        end
    end

    // compare every cycle, then drive the free-running stimulus
    always @(negedge clk) begin
        if (rst_n) begin
            check(mode_o == 2'(m_mode), "R2 mode", mode_o, m_mode);
            check(track_o == e_track, "R9 track", track_o, e_track);
            for (int i = 0; i < 4; i++)
                check(valid_o[i] == e_valid[i] && char_o[i*10 +: 10] == e_char[i], m_tag,
                      {valid_o[i], char_o[i*10 +: 10]}, {e_valid[i], e_char[i]});
        end
        cyc++;
        ref_s = (cyc % 8) < 4;
        case (shr_sel)
            1: shr_s = ((cyc + shr_ph) % 8) < 4;
            2: shr_s = (cyc % 100) == 0;
            default: shr_s = 1'b0;
        endcase
        aux_s = aux_on != 0 && (cyc % 8) < 4;
        for (int i = 0; i < 4; i++) begin
            lane_s[i] = lane_on != 0 && ((cyc + 2*i + 1) % 8) < 4;
            data_s[i*10 +: 10] = hold_on != 0 ? hold_v[i] : 10'((cyc*37 + i*113 + (cyc >> 3)) & 1023);
        end
    end

    task automatic count_valid(input int n, output int c);
        c = 0;
        repeat (n) begin @(posedge clk); #1; if (valid_o[0]) c++; end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        int c;
        hold_v[0] = 10'h001; hold_v[1] = 10'h2AA; hold_v[2] = 10'h155; hold_v[3] = 10'h300;
        wait_cyc(4);
        check(valid_o == 0 && char_o == 0 && mode_o == 0 && track_o == 0, "R11 reset", {valid_o, mode_o}, 0);
        rst_n = 1'b1;
        wait_cyc(200);
        check(mode_o == 2'b00, "R2 reference", mode_o, 0);
        count_valid(80, c);
        check(c == 10, "R4 count", c, 10);
        hold_on = 1; wait_cyc(20);
        check(char_o == {hold_v[3], hold_v[2], hold_v[1], hold_v[0]}, "R10 layout", char_o,
              {hold_v[3], hold_v[2], hold_v[1], hold_v[0]});
        hold_on = 0;
        single_s = 1'b0; wait_cyc(64); single_s = 1'b1; wait_cyc(150);
        check(mode_o == 2'b00, "R3 glitch", mode_o, 0);
        single_s = 1'b0; wait_cyc(200);
        check(mode_o == 2'b01, "R5 mode", mode_o, 1);
        count_valid(80, c);
        check(c == 20, "R5 count", c, 20);
        single_s = 1'b1; shr_sel = 1; wait_cyc(200);
        check(mode_o == 2'b10, "R6 mode", mode_o, 2);
        check(track_o == 1'b1, "R9 track on", track_o, 1);
        lock_s = 1'b1; wait_cyc(40);
        check(track_o == 1'b0, "R9 track off", track_o, 0);
        shr_ph = 4; wait_cyc(40);
        count_valid(80, c);
        check(c == 10, "R8 drift", c, 10);
        lock_s = 1'b0; aux_on = 1; lane_on = 1; wait_cyc(200);
        check(mode_o == 2'b11, "R7 mode", mode_o, 3);
        lock_s = 1'b1; wait_cyc(60);
        lock_s = 1'b0; shr_sel = 2; wait_cyc(260);
        check(mode_o == 2'b00, "R1 sparse", mode_o, 0);
        wait_cyc(20);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule